// File: doc/BRIEF.md
# DRAM refresh and power-up sequencer

This block keeps an asynchronous DRAM of 512 rows alive and brings it up after reset. It first holds every strobe inactive for a programmable start-up pause. It then issues a fixed number of plain RAS pulses, with the column strobes left high, to wake the array. Only after that does it raise `ready`, and from that point the access controller may use the memory.

Once ready, a pacing timer raises a refresh request at a fixed interval of clock cycles. The default interval is the 8 ms retention window divided by 512 rows, rounded down. The request is held until the access controller answers with a grant while the sequencer is idle. The sequencer then runs a refresh cycle in which the column strobes fall before RAS. In this kind of refresh the memory supplies the row from its own counter, so no address is driven and the data bus is not used. If a new interval expires while a request is still outstanding, a sticky overflow flag is set.

All durations are parameters in clock cycles. By default they are derived from a clock-period parameter in nanoseconds, so the block can be retimed for another clock by changing one value.

Top module: `dram_refresh_seq`

## Requirements
- R1: While reset is held, `ras_n`, `lcas_n` and `ucas_n` are 1, and `ref_req`, `ready` and `overflow` are 0.
- R2: For the first PAUSE_CYC clock edges after reset is released, all three strobes stay at 1.
- R3: After the pause, INIT_CNT pulses appear on `ras_n`, each low for RAS_ACT_CYC cycles and then high for RAS_PRE_CYC cycles, while both column strobes stay at 1 until `ready` is set.
- R4: `ready` becomes 1 in the cycle after the last initialization precharge cycle and stays 1 until reset.
- R5: Once ready, a refresh tick occurs every REF_INT_CYC cycles. The first `ref_req` is seen REF_INT_CYC cycles after `ready` rises.
- R6: `ref_gnt` is acted on only when the sequencer is idle with a request pending. At any other time it leaves the strobes unchanged.
- R7: A granted refresh drives the column strobe(s) low for CAS_LEAD_CYC cycles. Then `ras_n` goes low for RAS_ACT_CYC cycles while the column strobes stay low. Then all strobes return high together for at least RAS_PRE_CYC cycles before any further strobe activity.
- R8: `ref_req` stays 1 from the cycle after its tick until the last precharge cycle of the refresh it started. While `ready` is 1 and `ref_req` is 0, all strobes are 1.
- R9: A tick that comes while a request is pending, other than in that request's final precharge cycle, sets `overflow`. Only reset clears it, and the pending request stays raised.
- R10: With BOTH_CAS=1 both column strobes move together during refresh. With BOTH_CAS=0 only `lcas_n` moves and `ucas_n` stays 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_gnt | input | 1 | Grant from the access controller: the bus may be used for refresh |
| ref_req | output | 1 | Refresh request pending or in progress |
| ras_n | output | 1 | Row strobe to the DRAM, active low |
| lcas_n | output | 1 | Lower-byte column strobe, active low |
| ucas_n | output | 1 | Upper-byte column strobe, active low |
| ready | output | 1 | Initialization finished; normal access allowed |
| overflow | output | 1 | Sticky flag: a refresh interval expired with a request still outstanding |

## Verification
The bench holds the grant high throughout the pause and the initialization pulses. A design that listened to it early would drop a column strobe before `ready`, or cut short the wake-up pulse train. The bench then withholds the grant across two whole intervals. This catches a design that loses the pending request, drops `ref_req` early, or never sets or later clears `overflow`. It also leaves the grant high while nothing is pending, which exposes a sequencer that starts a refresh without a request. A second instance built with only the lower strobe is compared in the same run, so a design that fails to keep `ucas_n` high in that variant is seen at once.

// File: rtl/refseq_pkg.sv
package refseq_pkg;

    typedef enum logic [2:0] {
        ST_PAUSE,
        ST_WAKE_LOW,
        ST_WAKE_HIGH,
        ST_IDLE,
        ST_CBR_CAS,
        ST_CBR_RAS,
        ST_CBR_PRE
    } seq_state_e;

    function automatic int ceil_div(input int num, input int den);
        return (num + den - 1) / den;
    endfunction

    function automatic int max4(input int a, input int b, input int c, input int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/refseq_pacer.sv
module refseq_pacer #(
    parameter int REF_INT_CYC = 781
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic done,
    output logic pend,
    output logic ovf
);
    localparam int TW = $clog2(REF_INT_CYC + 1);

    typedef struct packed {
        logic [TW-1:0] tmr;
        logic          pend;
        logic          ovf;
    } pacer_t;

    pacer_t r_q, r_d;
    logic   tick;

    always_comb begin
        r_d  = r_q;
        tick = 1'b0;
        if (run) begin
            if (r_q.tmr == TW'(REF_INT_CYC - 1)) begin
                tick     = 1'b1;
                r_d.tmr  = '0;
            end else begin
                r_d.tmr  = r_q.tmr + 1'b1;
            end
        end
        if (tick && r_q.pend && !done) begin
            r_d.ovf = 1'b1;
        end
        r_d.pend = tick | (r_q.pend & ~done);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign pend = r_q.pend;
    assign ovf  = r_q.ovf;
endmodule

// File: rtl/refseq_fsm.sv
module refseq_fsm
    import refseq_pkg::*;
#(
    parameter int PAUSE_CYC    = 10000,
    parameter int INIT_CNT     = 8,
    parameter int RAS_ACT_CYC  = 3,
    parameter int RAS_PRE_CYC  = 2,
    parameter int CAS_LEAD_CYC = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pend,
    input  logic gnt,
    output logic ras_n,
    output logic cas_n,
    output logic rdy,
    output logic done
);
    localparam int CNT_MAX = max4(PAUSE_CYC, RAS_ACT_CYC, RAS_PRE_CYC, CAS_LEAD_CYC);
    localparam int CW      = $clog2(CNT_MAX + 1);
    localparam int IW      = $clog2(INIT_CNT + 1);

    typedef struct packed {
        seq_state_e     st;
        logic [CW-1:0]  cnt;
        logic [IW-1:0]  icnt;
        logic           rdy;
    } fsm_t;

    fsm_t r_q, r_d;
    logic cnt_end;

    always_comb begin
        r_d     = r_q;
        done    = 1'b0;
        cnt_end = 1'b0;
        r_d.cnt = r_q.cnt + 1'b1;
        unique case (r_q.st)
            ST_PAUSE: begin
                cnt_end = (r_q.cnt == CW'(PAUSE_CYC - 1));
                if (cnt_end) r_d.st = ST_WAKE_LOW;
            end
            ST_WAKE_LOW: begin
                cnt_end = (r_q.cnt == CW'(RAS_ACT_CYC - 1));
                if (cnt_end) r_d.st = ST_WAKE_HIGH;
            end
            ST_WAKE_HIGH: begin
                cnt_end = (r_q.cnt == CW'(RAS_PRE_CYC - 1));
                if (cnt_end) begin
                    if (r_q.icnt == IW'(INIT_CNT - 1)) begin
                        r_d.st  = ST_IDLE;
                        r_d.rdy = 1'b1;
                    end else begin
                        r_d.st   = ST_WAKE_LOW;
                        r_d.icnt = r_q.icnt + 1'b1;
                    end
                end
            end
            ST_IDLE: begin
                cnt_end = 1'b1;
                if (pend && gnt) r_d.st = ST_CBR_CAS;
            end
            ST_CBR_CAS: begin
                cnt_end = (r_q.cnt == CW'(CAS_LEAD_CYC - 1));
                if (cnt_end) r_d.st = ST_CBR_RAS;
            end
            ST_CBR_RAS: begin
                cnt_end = (r_q.cnt == CW'(RAS_ACT_CYC - 1));
                if (cnt_end) r_d.st = ST_CBR_PRE;
            end
            ST_CBR_PRE: begin
                cnt_end = (r_q.cnt == CW'(RAS_PRE_CYC - 1));
                if (cnt_end) begin
                    r_d.st = ST_IDLE;
                    done   = 1'b1;
                end
            end
            default: r_d.st = ST_PAUSE;
        endcase
        if (cnt_end) r_d.cnt = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_PAUSE, cnt: '0, icnt: '0, rdy: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign ras_n = ~((r_q.st == ST_WAKE_LOW) || (r_q.st == ST_CBR_RAS));
    assign cas_n = ~((r_q.st == ST_CBR_CAS) || (r_q.st == ST_CBR_RAS));
    assign rdy   = r_q.rdy;
endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq
    import refseq_pkg::*;
#(
    parameter int CLK_PERIOD_NS = 20,
    parameter int PAUSE_CYC     = ceil_div(200000, CLK_PERIOD_NS),
    parameter int INIT_CNT      = 8,
    parameter int REF_INT_CYC   = (8000000 / 512) / CLK_PERIOD_NS,
    parameter int RAS_ACT_CYC   = ceil_div(60, CLK_PERIOD_NS),
    parameter int RAS_PRE_CYC   = ceil_div(40, CLK_PERIOD_NS),
    parameter int CAS_LEAD_CYC  = ceil_div(10, CLK_PERIOD_NS),
    parameter bit BOTH_CAS      = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_gnt,
    output logic ref_req,
    output logic ras_n,
    output logic lcas_n,
    output logic ucas_n,
    output logic ready,
    output logic overflow
);
    logic pend;
    logic done;
    logic cas_n;
    logic rdy;

    refseq_pacer #(
        .REF_INT_CYC (REF_INT_CYC)
    ) u_pacer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (rdy),
        .done  (done),
        .pend  (pend),
        .ovf   (overflow)
    );

    refseq_fsm #(
        .PAUSE_CYC    (PAUSE_CYC),
        .INIT_CNT     (INIT_CNT),
        .RAS_ACT_CYC  (RAS_ACT_CYC),
        .RAS_PRE_CYC  (RAS_PRE_CYC),
        .CAS_LEAD_CYC (CAS_LEAD_CYC)
    ) u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .pend  (pend),
        .gnt   (ref_gnt),
        .ras_n (ras_n),
        .cas_n (cas_n),
        .rdy   (rdy),
        .done  (done)
    );

    generate
        if (BOTH_CAS) begin : g_both_cas
            assign lcas_n = cas_n;
            assign ucas_n = cas_n;
        end else begin : g_low_cas
            assign lcas_n = cas_n;
            assign ucas_n = 1'b1;
        end
    endgenerate

    assign ref_req = pend;
    assign ready   = rdy;
endmodule

// File: rtl/refseq_chk.sv
module refseq_chk #(
    parameter int RAS_ACT_CYC = 3,
    parameter int RAS_PRE_CYC = 2
) (
    input logic clk,
    input logic rst_n,
    input logic ras_n,
    input logic lcas_n,
    input logic ucas_n,
    input logic ready,
    input logic ref_req,
    input logic overflow
);
    logic [15:0] low_run_q;
    logic [15:0] high_run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_run_q  <= '0;
            high_run_q <= 16'(RAS_PRE_CYC);
        end else begin
            low_run_q  <= ras_n ? '0 : ((&low_run_q) ? low_run_q : low_run_q + 1'b1);
            high_run_q <= !ras_n ? '0 : ((&high_run_q) ? high_run_q : high_run_q + 1'b1);
        end
    end

    // R3 and R7: row strobe never released early
    a_r7_ras_min_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ras_n) |-> (low_run_q >= 16'(RAS_ACT_CYC)));

    // R3 and R7: precharge respected before the next fall
    a_r7_ras_min_high: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> (high_run_q >= 16'(RAS_PRE_CYC)));

    // R7: a column strobe is already low when the row strobe falls after ready
    a_r7_cas_leads_ras: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ras_n) && ready) |-> ($past(lcas_n) == 1'b0 || $past(ucas_n) == 1'b0));

    // R3: no column activity before ready
    a_r3_no_cas_before_ready: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |-> (lcas_n && ucas_n));

    // R4: ready is sticky
    a_r4_ready_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> ready);

    // R9: overflow is sticky
    a_r9_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);

    // R8: no strobe activity without an outstanding request
    a_r8_no_strobe_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !ref_req) |-> (ras_n && lcas_n && ucas_n));
endmodule

bind dram_refresh_seq refseq_chk #(
    .RAS_ACT_CYC (RAS_ACT_CYC),
    .RAS_PRE_CYC (RAS_PRE_CYC)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ras_n    (ras_n),
    .lcas_n   (lcas_n),
    .ucas_n   (ucas_n),
    .ready    (ready),
    .ref_req  (ref_req),
    .overflow (overflow)
);

// File: tb/sim_dram_refresh_seq.sv
module sim_dram_refresh_seq;
    localparam int CLK_PERIOD = 10;
    localparam int P  = 20;
    localparam int N  = 8;
    localparam int A  = 3;
    localparam int R  = 2;
    localparam int L  = 2;
    localparam int I  = 30;
    localparam int T0 = P + N * (A + R);
    localparam int LAST = 330;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic gnt = 1'b0;
    logic req0, ras0, lc0, uc0, rdy0, ovf0;
    logic req1, ras1, lc1, uc1, rdy1, ovf1;

    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    dram_refresh_seq #(.PAUSE_CYC(P), .INIT_CNT(N), .REF_INT_CYC(I), .RAS_ACT_CYC(A),
        .RAS_PRE_CYC(R), .CAS_LEAD_CYC(L), .BOTH_CAS(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .ref_gnt(gnt), .ref_req(req0), .ras_n(ras0),
        .lcas_n(lc0), .ucas_n(uc0), .ready(rdy0), .overflow(ovf0));

    dram_refresh_seq #(.PAUSE_CYC(P), .INIT_CNT(N), .REF_INT_CYC(I), .RAS_ACT_CYC(A),
        .RAS_PRE_CYC(R), .CAS_LEAD_CYC(L), .BOTH_CAS(1'b0)) u1 (
        .clk(clk), .rst_n(rst_n), .ref_gnt(gnt), .ref_req(req1), .ras_n(ras1),
        .lcas_n(lc1), .ucas_n(uc1), .ready(rdy1), .overflow(ovf1));

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic bit grant_at(input int c);
        if (c < T0)  return 1'b1;
        if (c < 95)  return 1'b0;
        if (c < 150) return 1'b1;
        if (c < 215) return 1'b0;
        return 1'b1;
    endfunction

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        int s_start = -1000;
        bit pend = 1'b0;
        bit ovf = 1'b0;
        repeat (3) begin
            @(negedge clk);
            chk(ras0 && lc0 && uc0, "R1", "strobes in reset", {ras0, lc0, uc0}, 7);
            chk(!req0 && !rdy0 && !ovf0, "R1", "flags in reset", {req0, rdy0, ovf0}, 0);
        end
        rst_n = 1'b1;
        for (int c = 0; c <= LAST; c++) begin
            bit e_ras, e_cas, inwin, tick, done, g, start;
            string stag;
            inwin = (c >= s_start + 1) && (c <= s_start + L + A + R);
            if (c < P) begin
                e_ras = 1'b1; e_cas = 1'b1; stag = "R2";
            end else if (c < T0) begin
                e_ras = ((c - P) % (A + R)) >= A; e_cas = 1'b1; stag = "R3";
            end else if (inwin) begin
                e_cas = !(c <= s_start + L + A);
                e_ras = !((c >= s_start + L + 1) && (c <= s_start + L + A));
                stag = "R7";
            end else begin
                e_ras = 1'b1; e_cas = 1'b1; stag = "R6 R8";
            end
            chk(ras0 == e_ras, stag, "ras_n", ras0, e_ras);
            chk(lc0 == e_cas && uc0 == e_cas, stag, "lcas_n/ucas_n", {lc0, uc0}, {e_cas, e_cas});
            chk(rdy0 == (c >= T0), "R4", "ready", rdy0, (c >= T0));
            chk(req0 == pend, "R5 R8", "ref_req", req0, pend);
            chk(ovf0 == ovf, "R9", "overflow", ovf0, ovf);
            chk(ras1 == e_ras && lc1 == e_cas, "R10", "lower-only strobes", {ras1, lc1}, {e_ras, e_cas});
            chk(uc1 == 1'b1, "R10", "lower-only ucas_n", uc1, 1);
            if (c == 235) begin
                chk(gnt && !req0 && ras0 && lc0, "R6", "grant without request", {gnt, req0, ras0, lc0}, 4'b1011);
            end
            if (c == T0 + I) begin
                chk(req0 == 1'b1, "R5", "first request timing", req0, 1);
            end
            g = grant_at(c);
            gnt = g;
            tick = (c >= T0) && ((c - T0) % I == I - 1);
            done = (c == s_start + L + A + R);
            start = (c >= T0) && pend && g && !inwin;
            if (tick && pend && !done) ovf = 1'b1;
            pend = tick || (pend && !done);
            if (start) s_start = c;
            @(negedge clk);
        end
        chk(ovf0 == 1'b1, "R9", "overflow after starved grant", ovf0, 1);
        finished = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule